// File: doc/BRIEF.md
# GPIO Pin Interrupt Controller

This block watches a bank of up to sixteen general-purpose input pins and turns pin activity into interrupt requests for a host processor. Each pin is first brought into the local clock domain. A per-channel detector then looks for one of five conditions: a rising edge, a falling edge, either edge, a high level or a low level. A detected condition on an enabled channel latches a pending bit. Pending bits that are not masked are combined into one registered interrupt line.

Software reaches the block through a small word-addressed register port with a write strobe and a combinational read path. It programs a 3-bit mode per channel and enables the channels it wants. The mask can be changed one bit at a time through separate set and clear registers, so no read-modify-write is needed, or it can be written whole to restore a saved value. Pending bits are acknowledged by writing ones to a clear register.

Top module: `gpio_irq_unit`

## Requirements
- R1: Each pin passes through a two-flop synchroniser. A pin change presented before clock edge k shows in the status register after edge k+2 and not after edge k+1.
- R2: The 3-bit mode codes for edges are 000 falling and 001 rising. Any code with bit 2 set (1xx) detects both edges. An edge is found by comparing the synchronised sample with the sample of the previous cycle.
- R3: Code 010 detects a low level and 011 a high level. The status bit is set on every cycle the level holds, so an acknowledge made while the level persists leaves the bit set.
- R4: Channels 0-7 keep their mode in mode register 0 and channels 8-15 in mode register 1. Channel c uses the nibble at bits 4*(c mod 8)+2 down to 4*(c mod 8). Bit 3 of each nibble reads as 0.
- R5: A status bit can only be set while that channel's enable bit is 1. Clearing the enable bit does not clear a status bit that is already pending.
- R6: Writing a 1 to a bit of the mask-set register masks that channel, and writing a 1 to a bit of the mask-clear register unmasks it. Zero bits in either write leave the mask unchanged. The mask register can also be written directly, and reads back the value written.
- R7: Writing a 1 to a bit of the acknowledge register clears that channel's status bit. If a new event on that channel arrives in the same cycle, the status bit stays set.
- R8: The status register shows channel c at bit c. Reading it does not change it.
- R9: irq_o equals the OR over channels of (status AND NOT mask), delayed by one clock.
- R10: Channels at or above NPINS read as zero in every register and ignore writes.
- R11: After reset, the enable, mask, status and mode registers are zero and irq_o is low.
- R12: The word addresses are 0 enable, 1 status (read only), 2 mask, 3 mask-set, 4 mask-clear, 5 acknowledge, 6 mode register 0 and 7 mode register 1. The mask-set, mask-clear and acknowledge addresses read as zero, and writes to the status address are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_i | input | NPINS | Asynchronous GPIO pin levels |
| reg_wen | input | 1 | Register write strobe, sampled on the clock edge |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| irq_o | output | 1 | Combined registered interrupt request |

## Verification
Two functions can act on the same status bit in the same cycle: a detected event and an acknowledge write. The bench provokes this in two ways. In the first, it times a pin toggle on a both-edges channel so that the acknowledge write is sampled on exactly the clock edge where the synchronised edge reaches the status register. In the second, it acknowledges a level-mode channel while the level still holds. In both cases the bit must read as set right after the write. A plain acknowledge with no coincident event serves as the control and must clear the bit.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
   localparam int NCH_MAX = 16;
   localparam int REG_AW  = 3;
   localparam int DATA_W  = 32;

   localparam logic [REG_AW-1:0] ADR_ENABLE  = 3'd0;
   localparam logic [REG_AW-1:0] ADR_STATUS  = 3'd1;
   localparam logic [REG_AW-1:0] ADR_MASK    = 3'd2;
   localparam logic [REG_AW-1:0] ADR_MSET    = 3'd3;
   localparam logic [REG_AW-1:0] ADR_MCLR    = 3'd4;
   localparam logic [REG_AW-1:0] ADR_ACK     = 3'd5;
   localparam logic [REG_AW-1:0] ADR_MODE_LO = 3'd6;
   localparam logic [REG_AW-1:0] ADR_MODE_HI = 3'd7;

   localparam logic [2:0] TRIG_FALL = 3'b000;
   localparam logic [2:0] TRIG_RISE = 3'b001;
   localparam logic [2:0] TRIG_LOW  = 3'b010;
   localparam logic [2:0] TRIG_HIGH = 3'b011;
   localparam logic [2:0] TRIG_ANY  = 3'b100;

   // Event decision for one channel from its mode and two successive samples.
   function automatic logic trig_hit(input logic [2:0] mode, input logic cur, input logic prv);
      logic hit;
      if (mode[2]) hit = cur ^ prv;
      else begin
         case (mode[1:0])
            2'b00:   hit = prv & ~cur;
            2'b01:   hit = ~prv & cur;
            2'b10:   hit = ~cur;
            default: hit = cur;
         endcase
      end
      return hit;
   endfunction
endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
   parameter int WIDTH  = 16,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   if (STAGES < 2) begin : g_bad_depth
      $error("gpio_irq_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] chain_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[s] <= '0;
            else        chain_q[s] <= d_i;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[s] <= '0;
            else        chain_q[s] <= chain_q[s-1];
         end
      end
   end

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
   import gpio_irq_pkg::*;
#(
   parameter int WIDTH = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [WIDTH-1:0]   smp_i,
   input  logic [3*WIDTH-1:0] mode_i,
   output logic [WIDTH-1:0]   evt_o
);
   logic [WIDTH-1:0] prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= smp_i;
   end

   for (genvar c = 0; c < WIDTH; c++) begin : g_ch
      assign evt_o[c] = trig_hit(mode_i[3*c +: 3], smp_i[c], prev_q[c]);
   end
endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit
   import gpio_irq_pkg::*;
#(
   parameter int NPINS     = 16,
   parameter int SYNC_DEPTH = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NPINS-1:0]  pin_i,
   input  logic              reg_wen,
   input  logic [2:0]        reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   output logic              irq_o
);
   if (NPINS < 1 || NPINS > NCH_MAX) begin : g_bad_npins
      $error("gpio_irq_unit: NPINS must lie in 1..16");
   end

   localparam logic [NCH_MAX-1:0] VALID = NCH_MAX'((32'd1 << NPINS) - 32'd1);
   localparam int HALF = NCH_MAX / 2;

   logic [NPINS-1:0]   smp;
   logic [NPINS-1:0]   evt;
   logic [3*NPINS-1:0] mode_flat;
   logic [NCH_MAX-1:0] evt_w;
   logic [NCH_MAX-1:0] enable_q, mask_q, status_q;
   logic [NCH_MAX-1:0] wr_bits, ack_bits;
   logic [2:0]         mode_q [NCH_MAX];
   logic               irq_q;

   gpio_irq_sync #(.WIDTH(NPINS), .STAGES(SYNC_DEPTH)) u_sync (
      .clk(clk), .rst_n(rst_n), .d_i(pin_i), .q_o(smp)
   );

   always_comb begin
      for (int c = 0; c < NPINS; c++) mode_flat[3*c +: 3] = mode_q[c];
   end

   gpio_irq_detect #(.WIDTH(NPINS)) u_detect (
      .clk(clk), .rst_n(rst_n), .smp_i(smp), .mode_i(mode_flat), .evt_o(evt)
   );

   always_comb begin
      evt_w = '0;
      evt_w[NPINS-1:0] = evt;
   end

   assign wr_bits  = reg_wdata[NCH_MAX-1:0] & VALID;
   assign ack_bits = (reg_wen && reg_addr == ADR_ACK) ? wr_bits : '0;

   // Mode storage: one 3-bit field per channel, unused channels tied to zero.
   for (genvar c = 0; c < NCH_MAX; c++) begin : g_mode
      localparam int SLOT = c % HALF;
      localparam logic [2:0] MADR = (c < HALF) ? ADR_MODE_LO : ADR_MODE_HI;
      if (c < NPINS) begin : g_used
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) mode_q[c] <= TRIG_FALL;
            else if (reg_wen && reg_addr == MADR) mode_q[c] <= reg_wdata[4*SLOT +: 3];
         end
      end else begin : g_unused
         assign mode_q[c] = 3'b000;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         enable_q <= '0;
         mask_q   <= '0;
      end else if (reg_wen) begin
         case (reg_addr)
            ADR_ENABLE: enable_q <= wr_bits;
            ADR_MASK:   mask_q   <= wr_bits;
            ADR_MSET:   mask_q   <= mask_q | wr_bits;
            ADR_MCLR:   mask_q   <= mask_q & ~wr_bits;
            default:    ;
         endcase
      end
   end

   // A fresh event outranks an acknowledge aimed at the same channel.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) status_q <= '0;
      else        status_q <= (status_q & ~ack_bits) | (evt_w & enable_q);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_q <= 1'b0;
      else        irq_q <= |(status_q & ~mask_q);
   end
   assign irq_o = irq_q;

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         ADR_ENABLE: reg_rdata[NCH_MAX-1:0] = enable_q;
         ADR_STATUS: reg_rdata[NCH_MAX-1:0] = status_q;
         ADR_MASK:   reg_rdata[NCH_MAX-1:0] = mask_q;
         ADR_MODE_LO: for (int s = 0; s < HALF; s++) reg_rdata[4*s +: 3] = mode_q[s];
         ADR_MODE_HI: for (int s = 0; s < HALF; s++) reg_rdata[4*s +: 3] = mode_q[s+HALF];
         default:    reg_rdata = '0;
      endcase
   end
endmodule

// File: rtl/gpio_irq_checker.sv
module gpio_irq_checker
   import gpio_irq_pkg::*;
#(
   parameter int NPINS = 16
) (
   input logic               clk,
   input logic               rst_n,
   input logic               reg_wen,
   input logic [2:0]         reg_addr,
   input logic [31:0]        reg_wdata,
   input logic [NCH_MAX-1:0] status,
   input logic [NCH_MAX-1:0] mask,
   input logic [NCH_MAX-1:0] enable,
   input logic [NCH_MAX-1:0] evt,
   input logic               irq
);
   localparam logic [NCH_MAX-1:0] VALID = NCH_MAX'((32'd1 << NPINS) - 32'd1);

   a_r5_enable_gate: assert property (@(posedge clk) disable iff (!rst_n)
      ((status & ~$past(status) & ~$past(enable)) == '0));

   a_r6_mask_set: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wen && reg_addr == ADR_MSET) |=>
         ((mask & $past(reg_wdata[NCH_MAX-1:0] & VALID)) == $past(reg_wdata[NCH_MAX-1:0] & VALID)));

   a_r6_mask_clr: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wen && reg_addr == ADR_MCLR) |=> ((mask & $past(reg_wdata[NCH_MAX-1:0])) == '0));

   a_r7_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wen && reg_addr == ADR_ACK) |=>
         ((status & $past(reg_wdata[NCH_MAX-1:0]) & ~$past(evt & enable)) == '0));

   a_r7_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
      ((status & $past(evt & enable)) == $past(evt & enable)));

   a_r9_irq_combine: assert property (@(posedge clk) disable iff (!rst_n)
      (irq == $past(|(status & ~mask))));
endmodule

bind gpio_irq_unit gpio_irq_checker #(.NPINS(NPINS)) u_gpio_irq_checker (
   .clk(clk), .rst_n(rst_n), .reg_wen(reg_wen), .reg_addr(reg_addr),
   .reg_wdata(reg_wdata), .status(status_q), .mask(mask_q),
   .enable(enable_q), .evt(evt_w), .irq(irq_o)
);

// File: tb/gpio_irq_unit_bench.sv
`timescale 1ns/1ps
module gpio_irq_unit_bench;
   localparam int NP = 12;
   localparam logic [31:0] VMASK = (32'd1 << NP) - 1;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [NP-1:0] pin = '0;
   logic        wen = 1'b0;
   logic [2:0]  addr = 3'd0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        irq;
   int          checks = 0;
   int          errors = 0;

   always #2.5 clk = ~clk;

   gpio_irq_unit #(.NPINS(NP)) u_gpio_irq_unit (
      .clk(clk), .rst_n(rst_n), .pin_i(pin), .reg_wen(wen), .reg_addr(addr),
      .reg_wdata(wdata), .reg_rdata(rdata), .irq_o(irq)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk); wen = 1'b1; addr = a; wdata = d;
      @(negedge clk); wen = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] d);
      @(negedge clk); addr = a; #1 d = rdata;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   // Expected status bit from the requirement text of R2 and R3.
   function automatic logic exp_hit(input logic [2:0] m, input logic old_v, input logic new_v);
      if (m[2]) return old_v != new_v;
      case (m[1:0])
         2'b00:   return old_v & ~new_v;
         2'b01:   return ~old_v & new_v;
         2'b10:   return ~old_v | ~new_v;
         default: return old_v | new_v;
      endcase
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [31:0] v;
      void'($urandom(32'd20111004));
      idle(4);
      rst_n = 1'b1;
      idle(1);

      // R11 reset state
      for (int a = 0; a < 8; a++) begin
         rd(3'(a), v);
         check("R11 reset register", v, 32'h0);
      end
      check("R11 reset irq", {31'h0, irq}, 32'h0);

      // R4 / R10 / R12 layout and ignored writes
      wr(3'd6, 32'hFFFF_FFFF); rd(3'd6, v); check("R4 mode lo nibbles", v, 32'h7777_7777);
      wr(3'd7, 32'hFFFF_FFFF); rd(3'd7, v); check("R10 mode hi unused", v, 32'h0000_7777);
      wr(3'd0, 32'hFFFF_FFFF); rd(3'd0, v); check("R10 enable unused", v, VMASK);
      wr(3'd0, 32'h0);
      wr(3'd1, 32'hFFFF_FFFF); rd(3'd1, v); check("R12 status write ignored", v, 32'h0);
      wr(3'd3, 32'h0000_0FFF); rd(3'd3, v); check("R12 mask-set reads zero", v, 32'h0);
      rd(3'd2, v); check("R6 mask after set", v, VMASK);
      wr(3'd4, 32'h0000_FFFF); rd(3'd2, v); check("R6 mask after clear", v, 32'h0);
      wr(3'd6, 32'h0000_0001); wr(3'd7, 32'h0);

      // R1 latency, R9 irq delay: channel 0 rising
      wr(3'd0, 32'h1);
      @(negedge clk); addr = 3'd1; pin[0] = 1'b1;
      @(posedge clk); @(posedge clk); #1 check("R1 not yet after two edges", rdata, 32'h0);
      @(posedge clk); #1 check("R1 set after three edges", rdata, 32'h1);
      check("R9 irq still low", {31'h0, irq}, 32'h0);
      @(posedge clk); #1 check("R9 irq one cycle later", {31'h0, irq}, 32'h1);

      // R6 mask and R9 fall
      wr(3'd3, 32'h1);
      check("R9 irq holds one cycle after mask", {31'h0, irq}, 32'h1);
      idle(1); check("R9 irq drops when masked", {31'h0, irq}, 32'h0);
      wr(3'd3, 32'h0); rd(3'd2, v); check("R6 zero set no effect", v, 32'h1);
      wr(3'd4, 32'h0); rd(3'd2, v); check("R6 zero clear no effect", v, 32'h1);
      wr(3'd4, 32'h1); rd(3'd2, v); check("R6 unmask", v, 32'h0);
      wr(3'd2, 32'h0000_0A5A); rd(3'd2, v); check("R6 direct restore", v, 32'h0000_0A5A);
      wr(3'd2, 32'h0);

      // R8 read without side effect
      rd(3'd1, v); check("R8 status first read", v, 32'h1);
      rd(3'd1, v); check("R8 status second read", v, 32'h1);

      // R7 plain ack, R5 enable hold and gate
      wr(3'd5, 32'h1); rd(3'd1, v); check("R7 ack clears", v, 32'h0);
      pin[0] = 1'b0; idle(3); pin[0] = 1'b1; idle(5);
      wr(3'd0, 32'h0); rd(3'd1, v); check("R5 disable keeps pending", v, 32'h1);
      wr(3'd5, 32'h1);
      pin[0] = 1'b0; idle(3); pin[0] = 1'b1; idle(5);
      rd(3'd1, v); check("R5 disabled channel stays clear", v, 32'h0);

      // R2 falling on channel 9 (mode register 1 slot 1)
      wr(3'd7, 32'h0000_0000); wr(3'd0, 32'h200);
      pin[9] = 1'b1; idle(5); rd(3'd1, v); check("R2 falling ignores rise", v, 32'h0);
      pin[9] = 1'b0; idle(5); rd(3'd1, v); check("R2 falling detected", v, 32'h200);
      wr(3'd5, 32'h200);

      // R3 level high on channel 1 re-sets after ack
      wr(3'd6, 32'h0000_0030); wr(3'd0, 32'h2);
      pin[1] = 1'b1; idle(5);
      wr(3'd5, 32'h2); rd(3'd1, v); check("R3 level re-sets after ack", v, 32'h2);
      pin[1] = 1'b0; idle(5);
      wr(3'd5, 32'h2); rd(3'd1, v); check("R3 cleared after level gone", v, 32'h0);

      // R7 same-cycle event and ack, channel 2 both edges
      wr(3'd6, 32'h0000_0400); wr(3'd0, 32'h4);
      pin[2] = 1'b1; idle(5);
      rd(3'd1, v); check("R2 both edges rise", v, 32'h4);
      @(negedge clk); pin[2] = 1'b0;
      @(posedge clk); @(posedge clk);
      @(negedge clk); wen = 1'b1; addr = 3'd5; wdata = 32'h4;
      @(negedge clk); wen = 1'b0;
      rd(3'd1, v); check("R7 event wins over ack", v, 32'h4);
      wr(3'd5, 32'h4); rd(3'd1, v); check("R7 control ack clears", v, 32'h0);

      // Random: one channel, random mode, pins and mask
      for (int it = 0; it < 200; it++) begin
         int          ch;
         logic [2:0]  m;
         logic        o, n;
         logic [31:0] mk, mv;
         logic        e;
         ch = int'($urandom_range(NP-1, 0));
         m  = 3'($urandom_range(7, 0));
         mk = $urandom & VMASK;
         wr(3'd0, 32'h0);
         wr(3'd5, VMASK);
         pin = NP'($urandom);
         o = pin[ch];
         idle(5);
         mv = 32'(m) << (4 * (ch % 8));
         wr(3'd6, (ch < 8) ? mv : 32'h0);
         wr(3'd7, (ch < 8) ? 32'h0 : mv);
         wr(3'd2, mk);
         wr(3'd0, 32'h1 << ch);
         wr(3'd5, 32'h1 << ch);
         n = 1'($urandom);
         pin = NP'($urandom);
         pin[ch] = n;
         idle(5);
         e = exp_hit(m, o, n);
         rd(3'd1, v);
         check(m[2] ? "R2 random both" : (m[1] ? "R3 random level" : "R2 random edge"),
               v, e ? (32'h1 << ch) : 32'h0);
         check("R9 random irq", {31'h0, irq}, {31'h0, e & ~mk[ch]});
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule